// File: doc/BRIEF.md
# Message Queue Controller for a CAN Node

This block holds the control state for one message queue of a CAN controller. A single 32-bit control word, writable one byte lane at a time, selects the queue direction, the slot count, the payload size per slot, the transmit priority, the retry policy and the interrupt enables. The message storage, the bit engine and arbitration sit elsewhere and talk to this block through single-cycle event pulses.

Both directions use the same index roles. The head index marks the slot the producer fills next and the tail index marks the slot the consumer drains next. In transmit direction software produces by writing the increment command and the bus engine consumes with `tx_done`. In receive direction the engine produces with `rx_store` and software consumes with the increment command. From the occupancy the block derives empty, half and full status and one direction-dependent interrupt. It also tracks the transmit request, the abort handshake, remote-frame triggering, a limited or unlimited retry policy and a self-clearing queue reset.

Top module: `msgq_ctrl`

## Requirements
- R1: Each `wr_be` bit, when `wr_en` is high, writes only its own byte of the control word. `rd_data` reads as follows: [31:29] payload code, [28:24] slot count minus one, [23] zero, [22:21] retry policy, [20:16] priority, [15:11] zero, [10] reset, [9] transmit request, [8] zero. The low byte is [7] direction (1 = transmit), [6] remote-trigger enable, [5] timestamp enable, [4] retries-exhausted enable, [3] overflow enable, [2] empty/full enable, [1] half enable and [0] not-full/not-empty enable.
- R2: While reset is asserted `rd_data` equals 32'h0060_0400. The reset bit reads 0 after the first clock edge that follows reset release.
- R3: The payload code, slot count and timestamp enable change only when `op_mode` is 3'b100. Any other mode leaves them unchanged, while the other fields in the same write still take effect.
- R4: `payload_bytes` maps payload codes 0 to 7 onto 8, 12, 16, 20, 24, 32, 48 and 64.
- R5: The depth is the slot-count field plus one, and both indices wrap modulo that depth. A write with bit 8 set advances the head in transmit direction or the tail in receive direction. `rx_store` advances the head only in receive direction, and `tx_done` advances the tail only in transmit direction. An advance of the head when full, or of the tail when empty, is ignored. The new indices and `fill_count` are visible after the clock edge that takes the event.
- R6: `fifo_empty` means a count of 0, `fifo_full` means count equals depth, and `fifo_half` means count is at least floor(depth/2).
- R7: In transmit direction, `irq_fifo` is (empty and bit 2) or (free slots at least floor(depth/2) and bit 1) or (not full and bit 0). In receive direction it is (full and bit 2) or (half and bit 1) or (not empty and bit 0).
- R8: `rx_store` while full in receive direction sets a sticky overflow flag. `irq_overflow` is that flag ANDed with bit 3, and only a queue reset clears the flag.
- R9: Writing bit 10 set makes the reset bit read 1. On the next edge the indices, count, overflow flag, request and exhausted flag clear, and the reset bit clears.
- R10: In transmit direction, a write with bit 9 set raises `tx_req`. The request drops when a `tx_done` empties the queue. In receive direction, writes to bit 9 have no effect.
- R11: Writing bit 9 as 0 while `tx_req` is 1, in transmit direction, clears the request and raises `abort_req` for exactly one cycle.
- R12: `rtr_rx` in transmit direction with bit 6 set raises `tx_req`. With bit 6 clear it does nothing.
- R13: Retry policy field: 00 allows no retry, 01 allows three retries, 10 and 11 allow unlimited retries. The field applies only when `retry_en` is high, and retries are unlimited otherwise. The `tx_fail` that exceeds the allowed retries sets a sticky exhausted flag and drops `tx_req`.
- R14: `irq_exhausted` is high exactly when the exhausted flag and bit 4 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 3 | Controller operating mode; 3'b100 is configuration |
| retry_en | input | 1 | Global enable for the retry-policy field |
| wr_en | input | 1 | Control word write strobe |
| wr_be | input | 4 | Byte-lane enables, bit n covers bits [8n+7:8n] |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word readback |
| rx_store | input | 1 | Engine stored one received message |
| tx_done | input | 1 | Engine sent the tail message successfully |
| tx_fail | input | 1 | Engine attempt for the tail message failed |
| rtr_rx | input | 1 | Remote request frame received for this queue |
| head_idx | output | DEPTH_W | Producer slot index |
| tail_idx | output | DEPTH_W | Consumer slot index |
| fill_count | output | DEPTH_W+1 | Occupied slots |
| fifo_empty | output | 1 | Occupancy is zero |
| fifo_half | output | 1 | Occupancy at least half the depth |
| fifo_full | output | 1 | Occupancy equals the depth |
| payload_bytes | output | 7 | Decoded payload size per slot |
| tx_req | output | 1 | Transmit request pending |
| abort_req | output | 1 | One-cycle abort request to the engine |
| irq_fifo | output | 1 | Direction-dependent status interrupt |
| irq_overflow | output | 1 | Receive overflow interrupt |
| irq_exhausted | output | 1 | Retries exhausted interrupt |

## Verification
Register fields, indices, count, request, abort pulse and sticky flags all change on the first rising edge after the write or event. The status and interrupt outputs follow combinationally from that state, so they are valid in the same cycle. A queue reset needs two edges: one to latch the bit and one to act on it, and that second edge is where the indices clear. The bench drives every stimulus on a falling edge, holds it across one rising edge, and samples at the next falling edge. For a queue reset it samples once after each of the two edges.

// File: rtl/msgq_pkg.sv
package msgq_pkg;

    localparam logic [2:0] MODE_CONFIG = 3'b100;

    // Control word fields, grouped by function
    typedef struct packed {
        logic [2:0] plsize;
        logic [4:0] slots_m1;
        logic [1:0] retry_pol;
        logic [4:0] prio;
        logic       tx_dir;
        logic       rtr_en;
        logic       ts_en;
        logic       ie_exh;
        logic       ie_ovf;
        logic       ie_edge;
        logic       ie_half;
        logic       ie_level;
    } cfg_t;

    function automatic logic [6:0] payload_decode(input logic [2:0] code);
        logic [6:0] b;
        case (code)
            3'd5:    b = 7'd32;
            3'd6:    b = 7'd48;
            3'd7:    b = 7'd64;
            default: b = 7'd8 + {2'b00, code, 2'b00};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/msgq_regs.sv
module msgq_regs
    import msgq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  op_mode,
    input  logic        wr_en,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    output cfg_t        cfg,
    output logic        clr_pend
);

    typedef struct packed {
        cfg_t cfg;
        logic clr;
    } regs_s;

    regs_s r_d, r_q;
    logic  in_cfg;

    assign in_cfg = (op_mode == MODE_CONFIG);

    always_comb begin
        r_d = r_q;
        // reset request acts for one cycle, then falls back
        if (r_q.clr) r_d.clr = 1'b0;
        if (wr_en && wr_be[3] && in_cfg) begin
            r_d.cfg.plsize   = wr_data[31:29];
            r_d.cfg.slots_m1 = wr_data[28:24];
        end
        if (wr_en && wr_be[2]) begin
            r_d.cfg.retry_pol = wr_data[22:21];
            r_d.cfg.prio      = wr_data[20:16];
        end
        if (wr_en && wr_be[1] && wr_data[10]) r_d.clr = 1'b1;
        if (wr_en && wr_be[0]) begin
            r_d.cfg.tx_dir   = wr_data[7];
            r_d.cfg.rtr_en   = wr_data[6];
            if (in_cfg) r_d.cfg.ts_en = wr_data[5];
            r_d.cfg.ie_exh   = wr_data[4];
            r_d.cfg.ie_ovf   = wr_data[3];
            r_d.cfg.ie_edge  = wr_data[2];
            r_d.cfg.ie_half  = wr_data[1];
            r_d.cfg.ie_level = wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q               <= '0;
            r_q.cfg.retry_pol <= 2'b11;
            r_q.clr           <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg      = r_q.cfg;
    assign clr_pend = r_q.clr;

    assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode != MODE_CONFIG) |=> ($stable(r_q.cfg.plsize) && $stable(r_q.cfg.slots_m1)
                                      && $stable(r_q.cfg.ts_en)));

    assert_reset_selfclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.clr && !(wr_en && wr_be[1] && wr_data[10])) |=> !r_q.clr);

endmodule

// File: rtl/msgq_ptrs.sv
module msgq_ptrs #(
    parameter int unsigned DEPTH_W = 5,
    localparam int unsigned CNT_W  = DEPTH_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [DEPTH_W-1:0] last_idx,
    input  logic               tx_dir,
    input  logic               sw_adv,
    input  logic               rx_store,
    input  logic               tx_done,
    output logic [DEPTH_W-1:0] head,
    output logic [DEPTH_W-1:0] tail,
    output logic [CNT_W-1:0]   count,
    output logic               empty,
    output logic               full,
    output logic               half,
    output logic               half_free,
    output logic               ovf
);

    typedef struct packed {
        logic [DEPTH_W-1:0] head;
        logic [DEPTH_W-1:0] tail;
        logic [CNT_W-1:0]   count;
        logic               ovf;
    } ptr_s;

    ptr_s p_d, p_q;

    logic [CNT_W-1:0] depth;
    logic [CNT_W-1:0] half_lvl;
    logic             head_req, tail_req, push, pop;

    assign depth    = CNT_W'(last_idx) + CNT_W'(1);
    assign half_lvl = depth >> 1;

    assign empty     = (p_q.count == '0);
    assign full      = (p_q.count == depth);
    assign half      = (p_q.count >= half_lvl);
    assign half_free = ((depth - p_q.count) >= half_lvl);

    // producer side is the head, consumer side the tail, in both directions
    assign head_req = tx_dir ? sw_adv  : rx_store;
    assign tail_req = tx_dir ? tx_done : sw_adv;
    assign push     = head_req && !full;
    assign pop      = tail_req && !empty;

    always_comb begin
        p_d = p_q;
        if (clr) begin
            p_d = '0;
        end else begin
            if (push) p_d.head = (p_q.head == last_idx) ? '0 : p_q.head + 1'b1;
            if (pop)  p_d.tail = (p_q.tail == last_idx) ? '0 : p_q.tail + 1'b1;
            p_d.count = p_q.count + CNT_W'(push) - CNT_W'(pop);
            if (!tx_dir && rx_store && full) p_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign head  = p_q.head;
    assign tail  = p_q.tail;
    assign count = p_q.count;
    assign ovf   = p_q.ovf;

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.count <= depth);

    assert_no_push_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr && !tail_req) |=> $stable(p_q.head));

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.ovf && !clr) |=> p_q.ovf);

endmodule

// File: rtl/msgq_txctl.sv
module msgq_txctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       tx_dir,
    input  logic       rtr_en,
    input  logic       retry_en,
    input  logic [1:0] retry_pol,
    input  logic       req_set_wr,
    input  logic       req_zero_wr,
    input  logic       rtr_rx,
    input  logic       tx_done,
    input  logic       tx_fail,
    input  logic       last_msg,
    output logic       tx_req,
    output logic       abort_req,
    output logic       exhausted
);

    typedef struct packed {
        logic       req;
        logic       abort;
        logic [1:0] fails;
        logic       exh;
    } txs_s;

    txs_s t_d, t_q;
    logic       limited;
    logic [1:0] limit;

    assign limited = retry_en && !retry_pol[1];
    assign limit   = retry_pol[0] ? 2'd3 : 2'd0;

    always_comb begin
        t_d       = t_q;
        t_d.abort = 1'b0;
        if (clr) begin
            t_d = '0;
        end else if (tx_dir) begin
            if (req_set_wr) begin
                t_d.req = 1'b1;
            end else if (req_zero_wr && t_q.req) begin
                t_d.req   = 1'b0;
                t_d.abort = 1'b1;
            end
            if (rtr_rx && rtr_en) t_d.req = 1'b1;
            if (t_q.req && tx_done) begin
                t_d.fails = '0;
                if (last_msg) t_d.req = 1'b0;
            end
            if (t_q.req && tx_fail) begin
                if (limited && t_q.fails == limit) begin
                    t_d.exh   = 1'b1;
                    t_d.req   = 1'b0;
                    t_d.fails = '0;
                end else if (t_q.fails != 2'd3) begin
                    t_d.fails = t_q.fails + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign tx_req    = t_q.req;
    assign abort_req = t_q.abort;
    assign exhausted = t_q.exh;

    assert_abort_drops_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.abort |-> !t_q.req);

    assert_abort_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.abort |=> !t_q.abort);

    assert_exh_drops_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t_q.exh) |-> !t_q.req);

    assert_rx_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_dir && !t_q.req) |=> !t_q.req);

endmodule

// File: rtl/msgq_ctrl.sv
module msgq_ctrl
    import msgq_pkg::*;
#(
    parameter int unsigned DEPTH_W = 5,
    localparam int unsigned CNT_W  = DEPTH_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         op_mode,
    input  logic               retry_en,
    input  logic               wr_en,
    input  logic [3:0]         wr_be,
    input  logic [31:0]        wr_data,
    output logic [31:0]        rd_data,
    input  logic               rx_store,
    input  logic               tx_done,
    input  logic               tx_fail,
    input  logic               rtr_rx,
    output logic [DEPTH_W-1:0] head_idx,
    output logic [DEPTH_W-1:0] tail_idx,
    output logic [CNT_W-1:0]   fill_count,
    output logic               fifo_empty,
    output logic               fifo_half,
    output logic               fifo_full,
    output logic [6:0]         payload_bytes,
    output logic               tx_req,
    output logic               abort_req,
    output logic               irq_fifo,
    output logic               irq_overflow,
    output logic               irq_exhausted
);

    cfg_t cfg;
    logic clr_pend;
    logic lane1_wr, sw_adv, req_set_wr, req_zero_wr;
    logic half_free, ovf, exhausted;

    assign lane1_wr    = wr_en && wr_be[1];
    assign sw_adv      = lane1_wr && wr_data[8];
    assign req_set_wr  = lane1_wr && wr_data[9];
    assign req_zero_wr = lane1_wr && !wr_data[9];

    msgq_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_mode  (op_mode),
        .wr_en    (wr_en),
        .wr_be    (wr_be),
        .wr_data  (wr_data),
        .cfg      (cfg),
        .clr_pend (clr_pend)
    );

    msgq_ptrs #(.DEPTH_W(DEPTH_W)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_pend),
        .last_idx  (cfg.slots_m1[DEPTH_W-1:0]),
        .tx_dir    (cfg.tx_dir),
        .sw_adv    (sw_adv),
        .rx_store  (rx_store),
        .tx_done   (tx_done),
        .head      (head_idx),
        .tail      (tail_idx),
        .count     (fill_count),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .half      (fifo_half),
        .half_free (half_free),
        .ovf       (ovf)
    );

    msgq_txctl u_txctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr_pend),
        .tx_dir      (cfg.tx_dir),
        .rtr_en      (cfg.rtr_en),
        .retry_en    (retry_en),
        .retry_pol   (cfg.retry_pol),
        .req_set_wr  (req_set_wr),
        .req_zero_wr (req_zero_wr),
        .rtr_rx      (rtr_rx),
        .tx_done     (tx_done),
        .tx_fail     (tx_fail),
        .last_msg    (fill_count == CNT_W'(1)),
        .tx_req      (tx_req),
        .abort_req   (abort_req),
        .exhausted   (exhausted)
    );

    always_comb begin
        if (cfg.tx_dir)
            irq_fifo = (fifo_empty && cfg.ie_edge) || (half_free && cfg.ie_half)
                    || (!fifo_full && cfg.ie_level);
        else
            irq_fifo = (fifo_full && cfg.ie_edge) || (fifo_half && cfg.ie_half)
                    || (!fifo_empty && cfg.ie_level);
    end

    assign irq_overflow  = ovf && cfg.ie_ovf;
    assign irq_exhausted = exhausted && cfg.ie_exh;
    assign payload_bytes = payload_decode(cfg.plsize);

    assign rd_data = {cfg.plsize, cfg.slots_m1, 1'b0, cfg.retry_pol, cfg.prio,
                      5'b0, clr_pend, tx_req, 1'b0,
                      cfg.tx_dir, cfg.rtr_en, cfg.ts_en, cfg.ie_exh, cfg.ie_ovf,
                      cfg.ie_edge, cfg.ie_half, cfg.ie_level};

    assert_status_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));

endmodule

// File: tb/test_msgq_ctrl.sv
module test_msgq_ctrl;

    localparam int unsigned DW = 5;
    localparam int unsigned CW = DW + 1;
    localparam int NVEC = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op_mode = 3'b100;
    logic          retry_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_be = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic          rx_store = 1'b0, tx_done = 1'b0, tx_fail = 1'b0, rtr_rx = 1'b0;
    logic [DW-1:0] head_idx, tail_idx;
    logic [CW-1:0] fill_count;
    logic          fifo_empty, fifo_half, fifo_full;
    logic [6:0]    payload_bytes;
    logic          tx_req, abort_req, irq_fifo, irq_overflow, irq_exhausted;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    msgq_ctrl #(.DEPTH_W(DW)) i_msgq_ctrl (
        .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .retry_en(retry_en),
        .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data),
        .rx_store(rx_store), .tx_done(tx_done), .tx_fail(tx_fail), .rtr_rx(rtr_rx),
        .head_idx(head_idx), .tail_idx(tail_idx), .fill_count(fill_count),
        .fifo_empty(fifo_empty), .fifo_half(fifo_half), .fifo_full(fifo_full),
        .payload_bytes(payload_bytes), .tx_req(tx_req), .abort_req(abort_req),
        .irq_fifo(irq_fifo), .irq_overflow(irq_overflow), .irq_exhausted(irq_exhausted)
    );

    // {lanes[4], data[32], events{rx,done,fail,rtr}[4], count[6], {empty,full,irq}[3]}
    localparam logic [48:0] VEC [NVEC] = '{
        {4'b1000, 32'h4300_0000, 4'b0000, 6'd0, 3'b100},
        {4'b0001, 32'h0000_0007, 4'b0000, 6'd0, 3'b100},
        {4'b0000, 32'h0,         4'b1000, 6'd1, 3'b001},
        {4'b0000, 32'h0,         4'b1000, 6'd2, 3'b001},
        {4'b0000, 32'h0,         4'b1000, 6'd3, 3'b001},
        {4'b0000, 32'h0,         4'b1000, 6'd4, 3'b011},
        {4'b0000, 32'h0,         4'b1000, 6'd4, 3'b011},
        {4'b0010, 32'h0000_0100, 4'b0000, 6'd3, 3'b001},
        {4'b0000, 32'h0,         4'b0100, 6'd3, 3'b001},
        {4'b0010, 32'h0000_0100, 4'b0000, 6'd2, 3'b001},
        {4'b0010, 32'h0000_0100, 4'b0000, 6'd1, 3'b001},
        {4'b0010, 32'h0000_0100, 4'b0000, 6'd0, 3'b100},
        {4'b0010, 32'h0000_0100, 4'b0000, 6'd0, 3'b100},
        {4'b0001, 32'h0000_0081, 4'b0000, 6'd0, 3'b101},
        {4'b0010, 32'h0000_0100, 4'b0000, 6'd1, 3'b001},
        {4'b0010, 32'h0000_0100, 4'b0000, 6'd2, 3'b001},
        {4'b0010, 32'h0000_0100, 4'b0000, 6'd3, 3'b001},
        {4'b0010, 32'h0000_0100, 4'b0000, 6'd4, 3'b010},
        {4'b0010, 32'h0000_0100, 4'b0000, 6'd4, 3'b010},
        {4'b0000, 32'h0,         4'b0100, 6'd3, 3'b001}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, hold across one rising edge, release at the next falling edge
    task automatic wr(input logic [3:0] be, input logic [31:0] d);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0; wr_data = '0;
    endtask

    task automatic ev(input logic rx, input logic dn, input logic fl, input logic rt);
        rx_store = rx; tx_done = dn; tx_fail = fl; rtr_rx = rt;
        @(negedge clk);
        rx_store = 1'b0; tx_done = 1'b0; tx_fail = 1'b0; rtr_rx = 1'b0;
    endtask

    task automatic qreset();
        wr(4'b0010, 32'h0000_0400);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R2 reset word", rd_data, 32'h0060_0400);
        check("R2 reset count", {26'b0, fill_count}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset bit self clears", {31'b0, rd_data[10]}, 32'd0);

        // table: R5 indices/count, R6 flags, R7 status interrupt
        for (int i = 0; i < NVEC; i++) begin
            logic [48:0] v;
            v = VEC[i];
            wr_en = |v[48:45]; wr_be = v[48:45]; wr_data = v[44:13];
            {rx_store, tx_done, tx_fail, rtr_rx} = v[12:9];
            @(negedge clk);
            wr_en = 1'b0; wr_be = '0; wr_data = '0;
            {rx_store, tx_done, tx_fail, rtr_rx} = 4'b0;
            check($sformatf("R5 R6 R7 vector %0d", i),
                  {23'b0, fill_count, fifo_empty, fifo_full, irq_fifo}, {23'b0, v[8:0]});
        end
        check("R5 head wrap", {27'b0, head_idx}, 32'd0);
        check("R5 tail index", {27'b0, tail_idx}, 32'd1);

        // R4 payload sizes, R1 byte lanes
        check("R4 code 2", {25'b0, payload_bytes}, 32'd16);
        wr(4'b1000, 32'hE300_0000);
        check("R4 code 7", {25'b0, payload_bytes}, 32'd64);
        wr(4'b1000, 32'hA300_0000);
        check("R4 code 5", {25'b0, payload_bytes}, 32'd32);
        wr(4'b0100, 32'hFFFF_FFFF & 32'h00FF_0000);
        check("R1 lane 2 only", rd_data, 32'hA37F_0081);

        // R3 config-only fields locked outside configuration mode
        op_mode = 3'b000;
        wr(4'b1001, 32'hFF00_00A1);
        check("R3 locked fields", rd_data, 32'hA37F_0081);
        check("R3 payload kept", {25'b0, payload_bytes}, 32'd32);
        op_mode = 3'b100;
        wr(4'b0001, 32'h0000_00A1);
        check("R3 timestamp writable in config", {31'b0, rd_data[5]}, 32'd1);
        wr(4'b0001, 32'h0000_0081);

        // R9 queue reset takes two edges
        wr(4'b0010, 32'h0000_0400);
        check("R9 reset bit set", {31'b0, rd_data[10]}, 32'd1);
        check("R9 count held one cycle", {26'b0, fill_count}, 32'd3);
        @(negedge clk);
        check("R9 reset bit cleared", {31'b0, rd_data[10]}, 32'd0);
        check("R9 indices cleared", {22'b0, head_idx, tail_idx, fifo_empty}, {22'b0, 10'd0, 1'b1});

        // R10 request lifetime
        wr(4'b0010, 32'h0000_0100);
        wr(4'b0010, 32'h0000_0100);
        wr(4'b0010, 32'h0000_0200);
        check("R10 request set", {30'b0, tx_req, rd_data[9]}, 32'd3);
        ev(1'b0, 1'b1, 1'b0, 1'b0);
        check("R10 request held with one left", {31'b0, tx_req}, 32'd1);
        ev(1'b0, 1'b1, 1'b0, 1'b0);
        check("R10 request drops when drained", {26'b0, fill_count} | {31'b0, tx_req}, 32'd0);

        // R11 abort
        wr(4'b0010, 32'h0000_0300);
        check("R11 request before abort", {31'b0, tx_req}, 32'd1);
        wr(4'b0010, 32'h0000_0000);
        check("R11 abort pulse", {30'b0, tx_req, abort_req}, 32'd1);
        @(negedge clk);
        check("R11 abort one cycle", {31'b0, abort_req}, 32'd0);

        // R12 remote trigger
        ev(1'b0, 1'b0, 1'b0, 1'b1);
        check("R12 remote ignored when disabled", {31'b0, tx_req}, 32'd0);
        wr(4'b0001, 32'h0000_00C1);
        ev(1'b0, 1'b0, 1'b0, 1'b1);
        check("R12 remote sets request", {31'b0, tx_req}, 32'd1);
        wr(4'b0010, 32'h0000_0000);

        // R13 / R14 retry policy
        retry_en = 1'b1;
        wr(4'b0001, 32'h0000_0091);
        wr(4'b0100, 32'h003F_0000);
        wr(4'b0010, 32'h0000_0200);
        for (int k = 0; k < 3; k++) ev(1'b0, 1'b0, 1'b1, 1'b0);
        check("R13 three retries allowed", {30'b0, tx_req, irq_exhausted}, 32'd2);
        ev(1'b0, 1'b0, 1'b1, 1'b0);
        check("R13 R14 exhausted after fourth fail", {30'b0, tx_req, irq_exhausted}, 32'd1);
        qreset();
        check("R9 exhausted cleared by reset", {31'b0, irq_exhausted}, 32'd0);
        wr(4'b0100, 32'h001F_0000);
        wr(4'b0010, 32'h0000_0300);
        ev(1'b0, 1'b0, 1'b1, 1'b0);
        check("R13 no retry policy", {30'b0, tx_req, irq_exhausted}, 32'd1);
        wr(4'b0001, 32'h0000_0081);
        check("R14 enable masks flag", {31'b0, irq_exhausted}, 32'd0);
        qreset();
        retry_en = 1'b0;
        wr(4'b0010, 32'h0000_0300);
        for (int k = 0; k < 5; k++) ev(1'b0, 1'b0, 1'b1, 1'b0);
        check("R13 policy ignored without global enable", {31'b0, tx_req}, 32'd1);
        qreset();

        // R7 transmit-side enables, R6 half
        wr(4'b0001, 32'h0000_0084);
        check("R7 tx empty irq", {31'b0, irq_fifo}, 32'd1);
        wr(4'b0010, 32'h0000_0100);
        check("R7 tx empty irq off", {31'b0, irq_fifo}, 32'd0);
        wr(4'b0001, 32'h0000_0082);
        check("R7 tx half-empty irq", {31'b0, irq_fifo}, 32'd1);
        check("R6 half below level", {31'b0, fifo_half}, 32'd0);
        wr(4'b0010, 32'h0000_0100);
        check("R6 half at level", {31'b0, fifo_half}, 32'd1);
        wr(4'b0010, 32'h0000_0100);
        check("R7 tx half-empty irq off", {31'b0, irq_fifo}, 32'd0);

        // R8 overflow in receive direction
        wr(4'b0001, 32'h0000_0008);
        ev(1'b1, 1'b0, 1'b0, 1'b0);
        check("R8 full no overflow yet", {30'b0, fifo_full, irq_overflow}, 32'd2);
        ev(1'b1, 1'b0, 1'b0, 1'b0);
        check("R8 overflow irq", {31'b0, irq_overflow}, 32'd1);
        wr(4'b0010, 32'h0000_0200);
        check("R10 receive ignores request", {31'b0, tx_req}, 32'd0);
        qreset();
        check("R8 overflow cleared by reset", {31'b0, irq_overflow}, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule